// File: doc/BRIEF.md
# Test-and-Set Lock Unit with Exponential Backoff

This block arbitrates one lock bit among N requesters that share a bus. A requester asks for the lock by holding its acquire input high. The unit then runs an atomic test-and-set for it. The first bus cycle reads the lock bit. The second writes a one to it. The bus-lock output stays high across both cycles, so nothing can come between the read and the write. If the value read was zero, the requester now holds the lock and its acquired output goes high. Otherwise it waits out a backoff delay before it tries again. That delay is 1, 2, 4 and then 8 cycles on successive failures.

When several requesters are eligible in the same cycle, a rotating-priority arbiter picks exactly one of them. A holder frees the lock by raising its release input and keeping it high until its acquired output drops. While the bus is locked the release is held back, so that it cannot land between a test-and-set's read and its write. A release from a requester that does not hold the lock changes nothing and pulses an error output.

Top module: `tas_lock`

## Requirements
- R1: After reset, acquired, granted, bus_lock and rel_err are all zero and the lock is free.
- R2: Each test-and-set keeps bus_lock high for exactly two consecutive cycles: a read cycle followed by a write cycle. Throughout both cycles, granted is one-hot on the same requester. An idle requester whose acq_req is sampled high at a clock edge starts its operation at that edge.
- R3: If the value read was zero, the write cycle's closing edge raises that requester's acquired bit and lowers bus_lock at the same time. Starting from an idle unit with a free lock, acquired therefore goes high three edges after acq_req is first sampled.
- R4: A failed test-and-set leaves the lock set and leaves the current holder unchanged. The failing requester's acquired bit stays low.
- R5: After each failure, the requester waits d cycles before its next attempt. The delay d takes the values 1, 2, 4, 8, 8, ... on successive failures. For a lone contender, the starts of successive attempts are therefore 4, 5, 7, 11, 11 cycles apart.
- R6: A requester's delay returns to 1 once it acquires the lock. It also returns to 1 when the requester drops acq_req. In both cases the next two failures are again spaced 4 and then 5 cycles apart.
- R7: A holder that raises rel_req releases the lock at the first edge at which bus_lock is low: acquired falls and the lock becomes free. While bus_lock is high, the release is deferred.
- R8: Concurrent eligible requests are served in rotating order. The search starts at the index after the last requester granted, and starts at 0 after reset.
- R9: A release from a requester that does not hold the lock is ignored. rel_err goes high for one cycle, one edge after the release is sampled, and the holder keeps the lock.
- R10: At most one bit of acquired is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | N | Per-requester lock request, held high while wanted |
| rel_req | input | N | Per-requester release, held high until acquired drops |
| granted | output | N | One-hot owner of the current locked bus operation |
| acquired | output | N | Per-requester lock-held indication |
| bus_lock | output | 1 | High across the read and write cycles of a test-and-set |
| rel_err | output | 1 | One-cycle pulse after a release by a non-holder |

## Verification
On every cycle, the assertions check the following:
- acquired and granted are each at most one-hot.
- Every locked operation spans two cycles with a stable owner.
- The lock bit set equals some requester holding the lock.
- acquired rises only at a write cycle's end.
- The lock falls only while the bus is idle.
- A requester in backoff is never granted.

Some behaviours can only be shown by the bench's scenarios:
- the exact backoff spacing, its saturation, and its reset on acquisition or withdrawal;
- the rotating arbitration order;
- the deferral of a release during a locked operation;
- the error pulse for a bad release.

// File: rtl/tas_lock.sv
module tas_lock #(
  parameter int N    = 4,
  parameter int MAXD = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] acq_req,
  input  logic [N-1:0] rel_req,
  output logic [N-1:0] granted,
  output logic [N-1:0] acquired,
  output logic         bus_lock,
  output logic         rel_err
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int DW = $clog2(MAXD + 1);

  typedef enum logic [1:0] {IDLE, RD, WR} ph_t;

  ph_t           ph;
  logic [IW-1:0] own, rr, pick;
  logic          lock_bit, old, pick_v;
  logic [N-1:0]  held_q, elig, rel_ok;
  logic [DW-1:0] dly [N];
  logic [DW-1:0] wt  [N];

  assign bus_lock = (ph != IDLE);
  assign granted  = bus_lock ? (N'(1) << own) : '0;
  assign acquired = held_q;
  assign rel_ok   = (ph == IDLE) ? (rel_req & held_q) : '0;

  always_comb begin
    pick_v = 1'b0;
    pick   = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(rr) + k) % N;
      if (!pick_v && elig[idx]) begin
        pick_v = 1'b1;
        pick   = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= IDLE;
      own      <= '0;
      rr       <= '0;
      old      <= 1'b0;
      lock_bit <= 1'b0;
      held_q   <= '0;
      rel_err  <= 1'b0;
    end else begin
      rel_err <= |(rel_req & ~held_q);
      held_q  <= held_q & ~rel_ok;
      if (|rel_ok) lock_bit <= 1'b0;
      case (ph)
        IDLE: if (pick_v) begin
          ph  <= RD;
          own <= pick;
          rr  <= (int'(pick) == N - 1) ? '0 : pick + 1'b1;
        end
        RD: begin
          old <= lock_bit;
          ph  <= WR;
        end
        default: begin
          ph       <= IDLE;
          lock_bit <= 1'b1;
          if (!old) held_q[own] <= 1'b1;
        end
      endcase
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_req
    assign elig[i] = acq_req[i] & ~held_q[i] & (wt[i] == '0);

    always_ff @(posedge clk) begin
      if (!rst_n || !acq_req[i]) begin
        dly[i] <= DW'(1);
        wt[i]  <= '0;
      end else if (ph == WR && own == IW'(i)) begin
        if (!old) dly[i] <= DW'(1);
        else begin
          wt[i]  <= dly[i];
          dly[i] <= (dly[i] >= DW'(MAXD / 2)) ? DW'(MAXD) : (dly[i] << 1);
        end
      end else if (wt[i] != '0) begin
        wt[i] <= wt[i] - 1'b1;
      end
    end

    assert_wait_no_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wt[i] != '0) |-> !granted[i]);
    assert_dly_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dly[i] <= DW'(MAXD));
  end

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acquired));
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(granted));
  assert_two_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |=> (bus_lock && $stable(granted)));
  assert_lock_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_bit == (held_q != '0));
  assert_acq_at_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((held_q & ~$past(held_q)) != '0) |-> $past(ph == WR));
  assert_release_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_bit) |-> $past(ph == IDLE));
endmodule

// File: tb/sim_tas_lock.sv
module sim_tas_lock;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] acq_req = '0, rel_req = '0;
  logic [N-1:0] granted, acquired;
  logic bus_lock, rel_err;
  int ntests = 0, nfail = 0, excl_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tas_lock #(.N(N), .MAXD(8)) u0 (.clk, .rst_n, .acq_req, .rel_req,
    .granted, .acquired, .bus_lock, .rel_err);

  always @(negedge clk) if (rst_n && $countones(acquired) > 1) excl_bad++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic take(int i, string tag);
    acq_req[i] = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(tag, acquired, 32'(1 << i));
  endtask

  task automatic drop(int i, string tag);
    acq_req[i] = 1'b0; rel_req[i] = 1'b1;
    for (int k = 0; k < 12 && acquired[i]; k++) @(negedge clk);
    chk(tag, acquired[i], 0);
    rel_req[i] = 1'b0;
  endtask

  task automatic spacing(int i, int cnt, int exp0, int exp1, int exp2, int exp3, int exp4, string tag);
    int st [6];
    int e [5];
    int n = 0, c = 0;
    logic pg = granted[i];
    e = '{exp0, exp1, exp2, exp3, exp4};
    while (n < cnt && c < 120) begin
      @(negedge clk); c++;
      if (granted[i] && !pg) begin st[n] = c; n++; end
      pg = granted[i];
    end
    for (int k = 1; k < cnt; k++) chk(tag, 32'(st[k] - st[k-1]), 32'(e[k-1]));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 acquired", acquired, 0);
    chk("R1 granted", granted, 0);
    chk("R1 bus_lock", bus_lock, 0);
    chk("R1 rel_err", rel_err, 0);
  endtask

  task automatic t_acquire();
    acq_req[1] = 1'b1;
    @(negedge clk);
    chk("R2 read cycle bus_lock", bus_lock, 1);
    chk("R2 read cycle granted", granted, 4'b0010);
    chk("R3 not yet acquired", acquired, 0);
    @(negedge clk);
    chk("R2 write cycle bus_lock", bus_lock, 1);
    chk("R2 write cycle granted", granted, 4'b0010);
    @(negedge clk);
    chk("R2 bus released", bus_lock, 0);
    chk("R3 acquired", acquired, 4'b0010);
  endtask

  task automatic t_backoff();
    acq_req[2] = 1'b1;
    spacing(2, 6, 4, 5, 7, 11, 11, "R5 backoff spacing");
    chk("R4 holder kept", acquired, 4'b0010);
  endtask

  task automatic t_deferred_release();
    for (int k = 0; k < 20 && !(granted[2] && bus_lock); k++) @(negedge clk);
    acq_req[1] = 1'b0; rel_req[1] = 1'b1;
    @(negedge clk);
    chk("R7 release deferred while locked", acquired[1], 1);
    @(negedge clk);
    chk("R7 still held at bus idle", acquired[1], 1);
    @(negedge clk);
    chk("R7 released", acquired[1], 0);
    rel_req[1] = 1'b0;
    for (int k = 0; k < 40 && !acquired[2]; k++) @(negedge clk);
    chk("R7 waiter gets freed lock", acquired, 4'b0100);
    drop(2, "R7 release r2");
  endtask

  task automatic t_backoff_reset();
    take(1, "R6 r1 acquire");
    acq_req[2] = 1'b1;
    spacing(2, 3, 4, 5, 0, 0, 0, "R6 delay reset after acquire");
    acq_req[2] = 1'b0;
    repeat (4) @(negedge clk);
    acq_req[2] = 1'b1;
    spacing(2, 3, 4, 5, 0, 0, 0, "R6 delay reset after withdraw");
    acq_req[2] = 1'b0;
    repeat (4) @(negedge clk);
    drop(1, "R6 release r1");
  endtask

  task automatic t_bad_release();
    take(0, "R9 r0 acquire");
    chk("R9 no error before", rel_err, 0);
    rel_req[3] = 1'b1;
    @(negedge clk);
    rel_req[3] = 1'b0;
    chk("R9 error pulse", rel_err, 1);
    chk("R9 holder unchanged", acquired, 4'b0001);
    @(negedge clk);
    chk("R9 error one cycle", rel_err, 0);
    drop(0, "R9 release r0");
  endtask

  task automatic t_round_robin();
    acq_req[0] = 1'b1; acq_req[3] = 1'b1;
    @(negedge clk);
    chk("R8 rotation picks r3 after r0", granted, 4'b1000);
    @(negedge clk); @(negedge clk);
    chk("R8 r3 acquired", acquired, 4'b1000);
    @(negedge clk);
    chk("R8 r0 tries next", granted, 4'b0001);
    @(negedge clk); @(negedge clk);
    chk("R4 failed try keeps holder", acquired, 4'b1000);
    drop(3, "R8 release r3");
    for (int k = 0; k < 40 && !acquired[0]; k++) @(negedge clk);
    chk("R8 r0 acquires after release", acquired, 4'b0001);
    drop(0, "R8 release r0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_acquire();
    t_backoff();
    t_deferred_release();
    t_backoff_reset();
    t_bad_release();
    t_round_robin();
    chk("R10 mutual exclusion every cycle", 32'(excl_bad), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      ntests++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule